// File: doc/BRIEF.md
# RDS Block Quality Status Capture

This block produces an 8-bit read-only status byte describing the most recently completed 26-bit RDS block. While a block arrives bit by bit, it counts the bits that the demodulator marked as unreliable. When the decoder signals the end of the block, the block stores four things together in one cycle: the count, the block type code, a flag for an RBDS paging block E, and a flag saying whether the syndrome reached zero after error correction.

A sync-word mode input changes what the block-type field reports. In that mode the field shows the block the receiver expects next, taken from a free-running A, B, C, D sequence, instead of the block the decoder detected. Syndrome calculation and error correction are not part of this block. It only records their results as the decoder presents them.

Top module: `rds_blk_status`

## Requirements
- R1: After reset, and again after any later reset, `status` reads 0x00. The expected-block sequence restarts at A (code 00).
- R2: `status[7:4]` holds the number of cycles with `bit_stb`=1 and `bit_bad`=1 since the previous `blk_stb`. The value is captured on the `blk_stb` cycle and appears one clock later. Bit strobes with `bit_bad`=0, and `bit_bad` without `bit_stb`, are not counted.
- R3: The quality count saturates at 15 (0xF) when a block has more than 15 bad bits.
- R4: A bad bit strobed in the same cycle as `blk_stb` belongs to the ending block. It is included in the captured count. The next block's count starts from zero.
- R5: When `sync_mode`=0, `status[3:2]` holds the decoded `blk_type`, where 00 = A, 01 = B, 10 = C or C', and 11 = D.
- R6: `status[1]` holds `blk_is_e`, which is 1 for a paging block E and 0 otherwise. `status[0]` holds `syn_ok`, which is 1 when the syndrome is zero after correction. Both are captured on `blk_stb`.
- R7: The expected-block counter steps A→B→C→D→A on every `blk_stb`, in either mode. When `sync_mode`=1 at the strobe, `status[3:2]` takes the counter value held before that step.
- R8: All status fields change only in the cycle after a `blk_stb`. In every other cycle the byte holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One received RDS bit this cycle |
| bit_bad | input | 1 | Demodulator marks this bit unreliable (valid with bit_stb) |
| blk_stb | input | 1 | Decoder finished a 26-bit block this cycle |
| blk_type | input | 2 | Detected block code: 00 A, 01 B, 10 C/C', 11 D |
| blk_is_e | input | 1 | Detected block is a paging block E |
| syn_ok | input | 1 | Syndrome zero after correction |
| sync_mode | input | 1 | Report the expected block instead of the detected one |
| status | output | 8 | {quality[3:0], block[1:0], e, synz} |

## Verification
Two functions can fall in the same cycle: counting a bad bit and capturing the block at its end. The bench sets up this case by raising `bit_stb` and `bit_bad` together with `blk_stb`, both on a block that is still below saturation and on one that is already at 15. It then checks that the captured quality includes the final bit, or stays at 15, and that the block after it starts again from zero. The stimulus table also toggles `sync_mode` between blocks, so the expected-block step and the capture of the reported block type happen on the same strobe. The bench predicts the block field from its own A-to-D sequence model.

// File: rtl/rds_blk_pkg.sv
package rds_blk_pkg;
   localparam int BLK_W = 2;

   typedef enum logic [BLK_W-1:0] {
      BLK_A  = 2'b00,
      BLK_B  = 2'b01,
      BLK_CC = 2'b10,
      BLK_D  = 2'b11
   } blk_code_e;

   function automatic logic [BLK_W-1:0] blk_next(input logic [BLK_W-1:0] cur);
      return cur + 1'b1;
   endfunction
endpackage

// File: rtl/rds_badbit_counter.sv
module rds_badbit_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt_fin
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      if (inc && (cnt_q != CNT_MAX)) cnt_fin = cnt_q + 1'b1;
      else                           cnt_fin = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_fin;
   end

   p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX))
      else $error("count left saturation");

   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0))
      else $error("count not restarted after block");

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt_q))
      else $error("count moved without bad bit");
endmodule

// File: rtl/rds_blk_sequencer.sv
module rds_blk_sequencer
   import rds_blk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [BLK_W-1:0] exp_blk
);
   always_ff @(posedge clk) begin
      if (!rst_n)   exp_blk <= BLK_A;
      else if (adv) exp_blk <= blk_next(exp_blk);
   end

   p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (exp_blk == BLK_W'($past(exp_blk) + 1)))
      else $error("expected block did not step");

   p_seq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(exp_blk))
      else $error("expected block moved without strobe");
endmodule

// File: rtl/rds_blk_status.sv
module rds_blk_status
   import rds_blk_pkg::*;
#(
   parameter int QU_W     = 4,
   parameter bit HAS_SYNC = 1'b1,
   localparam int ST_W    = QU_W + BLK_W + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_stb,
   input  logic            bit_bad,
   input  logic            blk_stb,
   input  logic [1:0]      blk_type,
   input  logic            blk_is_e,
   input  logic            syn_ok,
   input  logic            sync_mode,
   output logic [ST_W-1:0] status
);
   localparam int Q_LO = BLK_W + 2;

   generate
      if (QU_W < 2 || QU_W > 8) begin : g_bad_qu_w
         $error("QU_W must lie in 2..8");
      end
   endgenerate

   logic [QU_W-1:0]  q_fin;
   logic [BLK_W-1:0] blk_rep;
   logic [ST_W-1:0]  st_q;

   rds_badbit_counter #(.CNT_W(QU_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (bit_stb & bit_bad),
      .clr     (blk_stb),
      .cnt_fin (q_fin)
   );

   generate
      if (HAS_SYNC) begin : g_sync
         logic [BLK_W-1:0] exp_blk;
         rds_blk_sequencer u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (blk_stb),
            .exp_blk (exp_blk)
         );
         assign blk_rep = sync_mode ? exp_blk : blk_type;
      end else begin : g_nosync
         assign blk_rep = blk_type;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       st_q <= '0;
      else if (blk_stb) st_q <= {q_fin, blk_rep, blk_is_e, syn_ok};
   end

   assign status = st_q;

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_stb |=> $stable(status))
      else $error("status changed without block strobe");

   p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      blk_stb |=> (status[1:0] == {$past(blk_is_e), $past(syn_ok)}))
      else $error("flag capture mismatch");

   p_type_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_stb && !sync_mode) |=> (status[Q_LO-1:2] == $past(blk_type)))
      else $error("detected type not captured");

   p_last_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_stb && bit_stb && bit_bad) |=> (status[ST_W-1:Q_LO] != '0))
      else $error("final bad bit lost");
endmodule

// File: tb/sim_rds_blk_status.sv
module sim_rds_blk_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_stb = 1'b0, bit_bad = 1'b0, blk_stb = 1'b0;
   logic [1:0] blk_type = 2'b00;
   logic       blk_is_e = 1'b0, syn_ok = 1'b0, sync_mode = 1'b0;
   logic [7:0] status;

   int total = 0;
   int bad = 0;
   logic [1:0] seq_m = 2'b00;

   always #2 clk = ~clk;

   rds_blk_status u0 (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_bad(bit_bad),
      .blk_stb(blk_stb), .blk_type(blk_type), .blk_is_e(blk_is_e),
      .syn_ok(syn_ok), .sync_mode(sync_mode), .status(status)
   );

   // vector: [11] last bit bad, [10:6] bad bits before end, [5:4] type,
   // [3] e, [2] syn_ok, [1] sync_mode, [0] unused
   localparam int NV = 10;
   localparam logic [11:0] VEC [NV] = '{
      {1'b0, 5'd0,  2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
      {1'b0, 5'd3,  2'b01, 1'b0, 1'b1, 1'b0, 1'b0},
      {1'b0, 5'd7,  2'b10, 1'b1, 1'b0, 1'b0, 1'b0},
      {1'b1, 5'd4,  2'b11, 1'b0, 1'b0, 1'b0, 1'b0},
      {1'b0, 5'd15, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
      {1'b0, 5'd20, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0},
      {1'b1, 5'd14, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0},
      {1'b1, 5'd15, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0},
      {1'b0, 5'd1,  2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
      {1'b0, 5'd2,  2'b01, 1'b1, 1'b1, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: status=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic send_block(input int nbad, input logic last_bad, input logic [1:0] typ,
                             input logic e, input logic ok, input logic sm);
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         bit_stb = 1'b1;
         bit_bad = (i < nbad);
      end
      @(negedge clk);
      bit_stb = 1'b1; bit_bad = last_bad; blk_stb = 1'b1;
      blk_type = typ; blk_is_e = e; syn_ok = ok; sync_mode = sm;
      @(negedge clk);
      bit_stb = 1'b0; bit_bad = 1'b0; blk_stb = 1'b0;
   endtask

   function automatic logic [7:0] model(input int nbad, input logic last_bad, input logic [1:0] typ,
                                        input logic e, input logic ok, input logic sm,
                                        input logic [1:0] sq);
      int q;
      q = ((nbad > 25) ? 25 : nbad) + int'(last_bad);
      if (q > 15) q = 15;
      return {4'(q), (sm ? sq : typ), e, ok};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", status, 8'h00);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6 R7: table walk
      for (int v = 0; v < NV; v++) begin
         logic [7:0] exp_v;
         exp_v = model(int'(VEC[v][10:6]), VEC[v][11], VEC[v][5:4],
                       VEC[v][3], VEC[v][2], VEC[v][1], seq_m);
         send_block(int'(VEC[v][10:6]), VEC[v][11], VEC[v][5:4],
                    VEC[v][3], VEC[v][2], VEC[v][1]);
         seq_m = seq_m + 2'd1;
         check($sformatf("R2/R5/R6/R7 vector %0d", v), status, exp_v);
      end

      // R8: bad bits without block strobe leave status unchanged
      begin
         logic [7:0] held;
         held = status;
         for (int i = 0; i < 5; i++) begin
            @(negedge clk); bit_stb = 1'b1; bit_bad = 1'b1; blk_type = 2'b11; syn_ok = 1'b0;
         end
         @(negedge clk); bit_stb = 1'b0; bit_bad = 1'b1;
         @(negedge clk); bit_bad = 1'b0;
         check("R8 hold", status, held);
      end

      // R2: bad flag without bit strobe not counted; 5 earlier strobed bad bits count
      @(negedge clk); blk_stb = 1'b1; blk_type = 2'b10; blk_is_e = 1'b0; syn_ok = 1'b1; sync_mode = 1'b0;
      @(negedge clk); blk_stb = 1'b0;
      seq_m = seq_m + 2'd1;
      check("R2 ignore unstrobed", status, {4'd5, 2'b10, 1'b0, 1'b1});

      // R4: count restarts after strobe with coincident bad bit
      send_block(0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);
      seq_m = seq_m + 2'd1;
      send_block(0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
      seq_m = seq_m + 2'd1;
      check("R4 restart", status, {4'd0, 2'b01, 1'b0, 1'b0});

      // R1: reset mid-stream clears status and sequence
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset", status, 8'h00);
      rst_n = 1'b1; seq_m = 2'b00;
      send_block(2, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1);
      check("R7 restart at A", status, {4'd2, 2'b00, 1'b0, 1'b1});
      send_block(0, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1);
      check("R7 second B", status, {4'd0, 2'b01, 1'b0, 1'b1});

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule